// File: doc/BRIEF.md
# Nibble-Bus Firmware Hub Target Interface

This block is the device side of a 4-bit multiplexed firmware-hub style bus. It watches an active-low frame strobe and a nibble-wide address/data bus. It decodes a cycle header made of a start code, a device select nibble, a 28-bit address and a size nibble. It then carries out one single-byte memory read or write against a plain byte-wide internal memory port.

The host and this target share the nibble bus. The block keeps its own record of which side owns the bus in each clock. It drives its output only in the clocks it owns, through an output-enable, and it hands the bus back with a turnaround clock. Read cycles stall the host with wait sync codes. The number of wait codes has a parameter-set floor and is stretched until the memory reports completion. Write cycles end with a ready sync once the memory has taken the byte.

All bus fields are sampled on the rising clock edge. Each bus clock is one nibble. The memory port has a one-clock request pulse and a one-clock done pulse. Read data is taken in the clock that done is high.

Top module: `hubbus_target`

## Requirements
- R1: While reset is asserted and right after it, `lad_oe` and `mem_req` are 0.
- R2: A start is a nibble sampled with `frame_n` low: 1101 selects a read and 1110 a write. The nibble sampled in the last low-frame clock decides. If that nibble is any other value, no cycle follows.
- R3: The first nibble sampled with `frame_n` high after a start must equal `strap_id`. If it does not, the block returns to idle, never enables `lad_oe` and issues no request.
- R4: Seven address nibbles follow, most significant first, forming `mem_addr[27:0]`. Then comes a size nibble. Only 0000 is accepted. Any other size value returns the block to idle with no request and no drive.
- R5: In a read, the two clocks after the size nibble, and in a write the two clocks after the second data nibble, belong to the host and `lad_oe` stays 0. The device drives from the third clock.
- R6: In the sync phase the device drives 0101 (wait) and then 0000 (ready) for one clock. `mem_req` rises one clock after the size nibble (read) or after the high data nibble (write). With latency L clocks from `mem_req` to `mem_done`, the number of wait codes is max(floor, L-1). The floor is `RD_WAIT` for reads and `WR_WAIT` for writes.
- R7: After a read's ready code, the device drives the low data nibble, then the high data nibble, then 1111 for one clock, and releases the bus on the following clock.
- R8: A write takes two data nibbles, low first, into `mem_wdata` with `mem_we`=1. After its sync codes it drives 1111 for one clock and releases the bus on the next.
- R9: `frame_n` low in any clock disables `lad_oe` in that same clock, abandons the current cycle and restarts start detection with that nibble.
- R10: Each accepted cycle produces exactly one `mem_req` pulse, one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Nibble sampled from the shared bus |
| strap_id | input | 4 | Strapped device select value |
| lad_out | output | 4 | Nibble driven onto the shared bus when enabled |
| lad_oe | output | 1 | Output enable for `lad_out` |
| mem_req | output | 1 | One-clock memory request pulse |
| mem_we | output | 1 | 1 for write, 0 for read, valid with `mem_req` |
| mem_addr | output | 28 | Byte address for the memory |
| mem_wdata | output | 8 | Write byte, valid with `mem_req` |
| mem_rdata | input | 8 | Read byte, valid while `mem_done` is high |
| mem_done | input | 1 | One-clock memory completion pulse |

## Verification
The bench builds the block with `RD_WAIT`=2, `WR_WAIT`=0 and seven address nibbles. It answers memory requests with latencies from 1 to 5 clocks. Reads therefore cover both cases: the wait floor sets the count (L up to 3) and the memory sets it (L of 4 and 5). Writes with L=1 reach ready with zero wait codes. Random cycles with junk nibbles and repeated start codes are mixed with directed cases: a wrong select nibble, a bad size nibble, a non-start last nibble, and aborts during the address and during the sync phase.

// File: rtl/hubbus_pkg.sv
package hubbus_pkg;

  localparam int WAIT_CNT_W = 8;
  typedef logic [WAIT_CNT_W-1:0] wait_cnt_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_SIZE,
    ST_WLO,
    ST_WHI,
    ST_HTA0,
    ST_HTA1,
    ST_SYNC,
    ST_RLO,
    ST_RHI,
    ST_DTA
  } hub_state_t;

  localparam logic [3:0] NIB_RD_START = 4'b1101;
  localparam logic [3:0] NIB_WR_START = 4'b1110;
  localparam logic [3:0] NIB_ONE_BYTE = 4'b0000;
  localparam logic [3:0] NIB_WAIT     = 4'b0101;
  localparam logic [3:0] NIB_READY    = 4'b0000;
  localparam logic [3:0] NIB_HIGH     = 4'b1111;

  function automatic logic start_code(input logic [3:0] n);
    return (n == NIB_RD_START) || (n == NIB_WR_START);
  endfunction

  function automatic logic sync_done(input wait_cnt_t waited,
                                     input wait_cnt_t floor_w,
                                     input logic data_ok);
    return data_ok && (waited >= floor_w);
  endfunction

  function automatic logic owns_bus(input hub_state_t s);
    return (s == ST_SYNC) || (s == ST_RLO) || (s == ST_RHI) || (s == ST_DTA);
  endfunction

endpackage

// File: rtl/hubbus_seq.sv
module hubbus_seq
  import hubbus_pkg::*;
#(
  parameter int ADDR_NIBS = 7,
  parameter int RD_WAIT   = 2,
  parameter int WR_WAIT   = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_n,
  input  logic [3:0] lad_in,
  input  logic [3:0] strap_id,
  input  logic       have_data,
  output hub_state_t state,
  output logic       is_wr,
  output logic       ev_id_hit,
  output logic       ev_accept,
  output logic       ev_wr_full,
  output logic       ev_sync_ok
);

  localparam int NC_W = $clog2(ADDR_NIBS + 1);
  localparam wait_cnt_t RD_FLOOR = wait_cnt_t'(RD_WAIT);
  localparam wait_cnt_t WR_FLOOR = wait_cnt_t'(WR_WAIT);

  logic [NC_W-1:0] nib_cnt;
  wait_cnt_t       waited;
  hub_state_t      nxt;

  assign ev_id_hit  = (state == ST_START) && frame_n && (lad_in == strap_id);
  assign ev_accept  = (state == ST_SIZE) && frame_n && (lad_in == NIB_ONE_BYTE);
  assign ev_wr_full = (state == ST_WHI) && frame_n;
  assign ev_sync_ok = (state == ST_SYNC) &&
                      sync_done(waited, is_wr ? WR_FLOOR : RD_FLOOR, have_data);

  always_comb begin
    nxt = state;
    if (!frame_n) begin
      nxt = start_code(lad_in) ? ST_START : ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  nxt = ST_IDLE;
        ST_START: nxt = ev_id_hit ? ST_ADDR : ST_IDLE;
        ST_ADDR:  if (nib_cnt == NC_W'(ADDR_NIBS - 1)) nxt = ST_SIZE;
        ST_SIZE:  nxt = !ev_accept ? ST_IDLE : (is_wr ? ST_WLO : ST_HTA0);
        ST_WLO:   nxt = ST_WHI;
        ST_WHI:   nxt = ST_HTA0;
        ST_HTA0:  nxt = ST_HTA1;
        ST_HTA1:  nxt = ST_SYNC;
        ST_SYNC:  if (ev_sync_ok) nxt = is_wr ? ST_DTA : ST_RLO;
        ST_RLO:   nxt = ST_RHI;
        ST_RHI:   nxt = ST_DTA;
        ST_DTA:   nxt = ST_IDLE;
        default:  nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      is_wr   <= 1'b0;
      nib_cnt <= '0;
      waited  <= '0;
    end else begin
      state <= nxt;
      if (!frame_n && start_code(lad_in)) is_wr <= (lad_in == NIB_WR_START);
      if (state == ST_ADDR && frame_n) nib_cnt <= nib_cnt + NC_W'(1);
      else                             nib_cnt <= '0;
      if (state == ST_SYNC && frame_n) begin
        if (waited != '1) waited <= waited + wait_cnt_t'(1);
      end else begin
        waited <= '0;
      end
    end
  end

endmodule

// File: rtl/hubbus_dpath.sv
module hubbus_dpath
  import hubbus_pkg::*;
#(
  parameter int ADDR_NIBS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [3:0]        lad_in,
  input  hub_state_t        state,
  input  logic              is_wr,
  input  logic              ev_accept,
  input  logic              ev_wr_full,
  input  logic              ev_sync_ok,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [4*ADDR_NIBS-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              have_data,
  output logic [3:0]        lad_out
);

  localparam int AW = 4 * ADDR_NIBS;

  logic [7:0] rbuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      have_data <= 1'b0;
      rbuf      <= '0;
    end else begin
      if (state == ST_ADDR && frame_n) mem_addr <= {mem_addr[AW-5:0], lad_in};
      if (state == ST_WLO && frame_n)  mem_wdata[3:0] <= lad_in;
      if (state == ST_WHI && frame_n)  mem_wdata[7:4] <= lad_in;
      mem_req <= (ev_accept && !is_wr) || ev_wr_full;
      if (ev_accept) mem_we <= is_wr;
      if (ev_accept) begin
        have_data <= 1'b0;
      end else if (mem_done) begin
        have_data <= 1'b1;
        rbuf      <= mem_rdata;
      end
    end
  end

  always_comb begin
    case (state)
      ST_SYNC: lad_out = ev_sync_ok ? NIB_READY : NIB_WAIT;
      ST_RLO:  lad_out = rbuf[3:0];
      ST_RHI:  lad_out = rbuf[7:4];
      default: lad_out = NIB_HIGH;
    endcase
  end

endmodule

// File: rtl/hubbus_target.sv
module hubbus_target
  import hubbus_pkg::*;
#(
  parameter int ADDR_NIBS = 7,
  parameter int RD_WAIT   = 2,
  parameter int WR_WAIT   = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic [3:0]  lad_in,
  input  logic [3:0]  strap_id,
  output logic [3:0]  lad_out,
  output logic        lad_oe,
  output logic        mem_req,
  output logic        mem_we,
  output logic [4*ADDR_NIBS-1:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  input  logic        mem_done
);

  hub_state_t state;
  logic       is_wr;
  logic       ev_id_hit;
  logic       ev_accept;
  logic       ev_wr_full;
  logic       ev_sync_ok;
  logic       have_data;

  hubbus_seq #(
    .ADDR_NIBS(ADDR_NIBS),
    .RD_WAIT  (RD_WAIT),
    .WR_WAIT  (WR_WAIT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .lad_in    (lad_in),
    .strap_id  (strap_id),
    .have_data (have_data),
    .state     (state),
    .is_wr     (is_wr),
    .ev_id_hit (ev_id_hit),
    .ev_accept (ev_accept),
    .ev_wr_full(ev_wr_full),
    .ev_sync_ok(ev_sync_ok)
  );

  hubbus_dpath #(
    .ADDR_NIBS(ADDR_NIBS)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .lad_in    (lad_in),
    .state     (state),
    .is_wr     (is_wr),
    .ev_accept (ev_accept),
    .ev_wr_full(ev_wr_full),
    .ev_sync_ok(ev_sync_ok),
    .mem_rdata (mem_rdata),
    .mem_done  (mem_done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .have_data (have_data),
    .lad_out   (lad_out)
  );

  // Release at once when the host reasserts the frame strobe.
  assign lad_oe = frame_n && owns_bus(state);

endmodule

// File: rtl/hubbus_chk.sv
module hubbus_chk
  import hubbus_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic [3:0] lad_in,
  input logic [3:0] strap_id,
  input logic [3:0] lad_out,
  input logic       lad_oe,
  input logic       mem_req,
  input hub_state_t state,
  input logic       have_data
);

  a_r3_mismatch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START && frame_n && lad_in != strap_id) |=> (state == ST_IDLE && !lad_oe));

  a_r4_bad_size_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SIZE && frame_n && lad_in != 4'b0000) |=> (state == ST_IDLE && !mem_req));

  a_r5_host_turn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HTA0 || state == ST_HTA1) |-> !lad_oe);

  a_r6_ready_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    (lad_oe && state == ST_SYNC && lad_out == NIB_READY) |-> have_data);

  a_r6_sync_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (lad_oe && state == ST_SYNC) |-> (lad_out == NIB_WAIT || lad_out == NIB_READY));

  a_r7_release_after_tar: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DTA && frame_n) |=> !lad_oe);

  a_r9_abort_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> (state == ST_IDLE || state == ST_START));

  a_r10_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

endmodule

bind hubbus_target hubbus_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .frame_n  (frame_n),
  .lad_in   (lad_in),
  .strap_id (strap_id),
  .lad_out  (lad_out),
  .lad_oe   (lad_oe),
  .mem_req  (mem_req),
  .state    (state),
  .have_data(have_data)
);

// File: tb/hubbus_target_bench.sv
module hubbus_target_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RD_WAIT = 2;
  localparam int WR_WAIT = 0;
  localparam logic [3:0] STRAP = 4'h6;
  localparam logic [3:0] RD_NIB = 4'hD;
  localparam logic [3:0] WR_NIB = 4'hE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  lad_in = 4'hF;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic        mem_req;
  logic        mem_we;
  logic [27:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        mem_done;

  hubbus_target #(.ADDR_NIBS(7), .RD_WAIT(RD_WAIT), .WR_WAIT(WR_WAIT)) u_hubbus_target (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in), .strap_id(STRAP),
    .lad_out(lad_out), .lad_oe(lad_oe), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_done(mem_done)
  );

  initial forever #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  logic       s_oe;
  logic [3:0] s_lad;

  // memory model state
  int          lat = 2;
  int          req_seen = 0;
  logic [27:0] last_addr = '0;
  logic        last_we = 1'b0;
  logic [7:0]  last_wdata = '0;
  logic [7:0]  mstore [0:255];
  logic [7:0]  ref_mem [0:255];

  function automatic logic [7:0] seed_byte(input int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  function automatic int exp_waits(input int l, input bit wr);
    int fl;
    fl = wr ? WR_WAIT : RD_WAIT;
    return (l - 1 > fl) ? l - 1 : fl;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic fr, input logic [3:0] nib);
    @(negedge clk);
    frame_n = fr;
    lad_in  = nib;
    #1;
    s_oe  = lad_oe;
    s_lad = lad_out;
  endtask

  initial begin : memmodel
    int cnt;
    logic [7:0] pidx;
    cnt = 0;
    pidx = '0;
    for (int i = 0; i < 256; i++) mstore[i] = seed_byte(i);
    mem_done  = 1'b0;
    mem_rdata = '0;
    forever begin
      @(posedge clk);
      mem_done <= 1'b0;
      if (mem_req) begin
        req_seen++;
        last_addr  = mem_addr;
        last_we    = mem_we;
        last_wdata = mem_wdata;
        if (mem_we) mstore[mem_addr[7:0]] = mem_wdata;
        pidx = mem_addr[7:0];
        cnt  = lat;
      end
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          mem_done  <= 1'b1;
          mem_rdata <= mstore[pidx];
        end
      end
    end
  end

  task automatic send_header(input bit wr, input int junk, input int starts,
                             input logic [3:0] idn, input logic [27:0] addr,
                             input logic [3:0] sz);
    for (int j = 0; j < junk; j++) step(1'b0, 4'h2 + 4'(j));
    for (int j = 0; j < starts - 1; j++) step(1'b0, wr ? RD_NIB : WR_NIB);
    step(1'b0, wr ? WR_NIB : RD_NIB);
    step(1'b1, idn);
    for (int j = 0; j < 7; j++) step(1'b1, addr[27-4*j -: 4]);
    step(1'b1, sz);
  endtask

  task automatic run_txn(input bit wr, input logic [27:0] addr, input logic [7:0] wd,
                         input int l, input int junk, input int starts);
    int base;
    int waits;
    logic [7:0] exp_rd;
    lat = l;
    base = req_seen;
    exp_rd = ref_mem[addr[7:0]];
    send_header(wr, junk, starts, STRAP, addr, 4'h0);
    if (wr) begin
      step(1'b1, wd[3:0]);
      step(1'b1, wd[7:4]);
    end
    step(1'b1, 4'hF);
    check(!s_oe, "R5", "host turnaround clock 1 oe", int'(s_oe), 0);
    step(1'b1, 4'hF);
    check(!s_oe, "R5", "host turnaround clock 2 oe", int'(s_oe), 0);
    waits = 0;
    step(1'b1, 4'hF);
    while (s_oe && s_lad == 4'h5 && waits < 40) begin
      waits++;
      step(1'b1, 4'hF);
    end
    check(s_oe && s_lad == 4'h0, wr ? "R8" : "R6", "ready sync", int'(s_lad), 0);
    check(waits == exp_waits(l, wr), "R6", "wait sync count", waits, exp_waits(l, wr));
    if (!wr) begin
      step(1'b1, 4'hF);
      check(s_oe && s_lad == exp_rd[3:0], "R7", "read low nibble", int'(s_lad), int'(exp_rd[3:0]));
      step(1'b1, 4'hF);
      check(s_oe && s_lad == exp_rd[7:4], "R7", "read high nibble", int'(s_lad), int'(exp_rd[7:4]));
    end
    step(1'b1, 4'hF);
    check(s_oe && s_lad == 4'hF, wr ? "R8" : "R7", "device turnaround", int'(s_lad), 15);
    step(1'b1, 4'hF);
    check(!s_oe, wr ? "R8" : "R7", "bus released", int'(s_oe), 0);
    check(req_seen == base + 1, "R10", "one request per cycle", req_seen - base, 1);
    check(last_addr == addr && last_we == wr, "R4", "memory address", int'(last_addr), int'(addr));
    if (wr) begin
      check(last_wdata == wd, "R8", "write byte", int'(last_wdata), int'(wd));
      ref_mem[addr[7:0]] = wd;
    end
  endtask

  // Drive n idle-ish steps with frame high and report whether oe or a request appeared.
  task automatic quiet_steps(input int n, input string req, input string what, input int base);
    bit seen;
    seen = 1'b0;
    for (int j = 0; j < n; j++) begin
      step(1'b1, 4'hF);
      if (s_oe) seen = 1'b1;
    end
    check(!seen, req, what, int'(seen), 0);
    check(req_seen == base, req, "no memory request", req_seen - base, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int base;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) ref_mem[i] = seed_byte(i);

    // R1: reset state
    repeat (3) @(negedge clk);
    check(!lad_oe && !mem_req, "R1", "outputs during reset", int'({lad_oe, mem_req}), 0);
    rst_n = 1'b1;
    step(1'b1, 4'hF);
    check(!s_oe && !mem_req, "R1", "outputs after reset", int'({s_oe, mem_req}), 0);

    // basic read and write, nominal latency
    run_txn(1'b0, 28'h1234503, 8'h00, 2, 0, 1);
    run_txn(1'b1, 28'hABCDE03, 8'hC7, 1, 0, 1);
    run_txn(1'b0, 28'h0000003, 8'h00, 1, 0, 1);

    // R2: last start wins (write code then read code), junk first
    run_txn(1'b0, 28'h7654302, 8'h00, 4, 2, 3);
    run_txn(1'b1, 28'h0F0F002, 8'h5A, 5, 1, 2);

    // R2: last low-frame nibble is not a start code
    base = req_seen;
    step(1'b0, RD_NIB);
    step(1'b0, 4'h3);
    step(1'b1, STRAP);
    quiet_steps(16, "R2", "no response after non-start nibble", base);

    // R3: select mismatch
    base = req_seen;
    send_header(1'b0, 0, 1, ~STRAP, 28'h0000001, 4'h0);
    quiet_steps(10, "R3", "no drive on select mismatch", base);

    // R4: bad size nibble
    base = req_seen;
    send_header(1'b0, 0, 1, STRAP, 28'h0000001, 4'h1);
    quiet_steps(10, "R4", "no drive on bad size", base);

    // R9: abort during address, then a normal cycle restarts at once
    step(1'b0, WR_NIB);
    step(1'b1, STRAP);
    step(1'b1, 4'h1);
    step(1'b1, 4'h2);
    run_txn(1'b0, 28'h5550001, 8'h00, 3, 0, 1);

    // R9: abort during the sync phase
    lat = 5;
    send_header(1'b0, 0, 1, STRAP, 28'h0000004, 4'h0);
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
    check(s_oe && s_lad == 4'h5, "R6", "wait sync before abort", int'(s_lad), 5);
    step(1'b0, 4'h0);
    check(!s_oe, "R9", "oe drops with frame low", int'(s_oe), 0);
    step(1'b1, 4'hF);
    check(!s_oe, "R9", "stays released after abort", int'(s_oe), 0);
    repeat (6) step(1'b1, 4'hF);
    run_txn(1'b0, 28'h0000004, 8'h00, 2, 0, 1);

    // random mix
    for (int k = 0; k < 40; k++) begin
      bit wr;
      logic [27:0] a;
      wr = 1'($urandom % 2);
      a  = (28'($urandom) & 28'hFFFFF00) | 28'($urandom % 8);
      run_txn(wr, a, 8'($urandom), 1 + int'($urandom % 5), int'($urandom % 3),
              1 + int'($urandom % 3));
      if ($urandom % 2 == 1) step(1'b1, 4'hF);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule